// File: doc/BRIEF.md
# Keypad Group-Select Input Register

This block is an 8-bit input register that reads an eight-button keypad. The keypad is wired as two groups of four buttons. Software writes a two-bit group-select field. A read then returns the four button lines of the enabled group or groups in the low nibble.

The select bits are active low. A zero enables a group, and enabling both groups merges them with an OR, so a press in either group pulls the shared line low. The returned nibble is the inverse of the pressed state: a pressed button reads 0 and an idle line reads 1. The two upper bits always read 1. The select field reads back from its stored value.

The raw button vector comes from outside the clock domain. It passes through a synchroniser before it reaches the read path. Reads are combinational and have no side effects.

Top module: `kpad_select_reg`

## Requirements
- R1: After reset the stored select field is 2'b00, and a read returns 8'hCF while no button is pressed.
- R2: Bits 7:6 of the read value are always 1.
- R3: A write with `wrEn` high stores `wrData[5:4]` as the select field. Those bits read back at positions 5:4 from the next clock edge. Written bits 7:6 and 3:0 have no effect on the read value.
- R4: With select 2'b11 (both groups disabled), read bits 3:0 are 4'hF whatever buttons are pressed.
- R5: With select 2'b10, read bit i (i = 0..3) is the inverse of button i+4.
- R6: With select 2'b01, read bit i (i = 0..3) is the inverse of button i.
- R7: With select 2'b00, read bit i is 0 when button i or button i+4 is pressed, and 1 otherwise.
- R8: A change on `btnRaw` reaches `rdData` after exactly two rising clock edges. After one edge the read value is unchanged.
- R9: Data on `wrData` while `wrEn` is low does not change the select field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| btnRaw | input | 8 | Raw button state, 1 = pressed. Bits 3:0 are group 0, bits 7:4 are group 1 |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Write data. Only bits 5:4 are stored |
| rdData | output | 8 | Read value: 2'b11, select field, inverted selected nibble |

## Verification
The merged-group case is the hardest to reach from the ports. It only shows a fault when the two nibbles differ, and the reset select value already merges them. The stimulus therefore presses disjoint buttons in each group under every select value, so a wrong routing or a missing OR changes the read value. Synchroniser depth is checked by sampling after one edge and again after two.

// File: rtl/kpad_pkg.sv
package kpad_pkg;
  localparam int GROUP_W   = 4;
  localparam int NUM_GROUP = 2;
  localparam int BTN_W     = GROUP_W * NUM_GROUP;
  localparam int REG_W     = 8;
  localparam int SEL_LSB   = 4;

  typedef struct packed {
    logic                 loadSel;
    logic [NUM_GROUP-1:0] selValue;
  } kpadStrobes_t;
endpackage

// File: rtl/kpad_ctrl.sv
module kpad_ctrl
  import kpad_pkg::*;
(
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output kpadStrobes_t     strobes
);
  logic [REG_W-NUM_GROUP-1:0] unusedWrBits;

  always_comb begin
    strobes.loadSel  = wrEn;
    strobes.selValue = wrData[SEL_LSB +: NUM_GROUP];
    unusedWrBits     = {wrData[REG_W-1:SEL_LSB+NUM_GROUP], wrData[SEL_LSB-1:0]};
  end
endmodule

// File: rtl/kpad_datapath.sv
module kpad_datapath
  import kpad_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [BTN_W-1:0] btnRaw,
  input  kpadStrobes_t     strobes,
  output logic [REG_W-1:0] rdData
);
  localparam int TOP_W = REG_W - SEL_LSB - NUM_GROUP;

  logic [BTN_W-1:0]     syncStage [SYNC_STAGES];
  logic [NUM_GROUP-1:0] selReg;
  logic [GROUP_W-1:0]   groupLine [NUM_GROUP];
  logic [GROUP_W-1:0]   mergedPress;

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncStage[s] <= '0;
        else if (s == 0) syncStage[s] <= btnRaw;
        else syncStage[s] <= syncStage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selReg <= '0;
    else if (strobes.loadSel) selReg <= strobes.selValue;
  end

  // Group g is enabled by select bit NUM_GROUP-1-g, active low.
  genvar g;
  generate
    for (g = 0; g < NUM_GROUP; g++) begin : g_group
      always_comb begin
        if (!selReg[NUM_GROUP-1-g])
          groupLine[g] = syncStage[SYNC_STAGES-1][g*GROUP_W +: GROUP_W];
        else
          groupLine[g] = '0;
      end
    end
  endgenerate

  always_comb begin
    mergedPress = '0;
    for (int k = 0; k < NUM_GROUP; k++) mergedPress = mergedPress | groupLine[k];
    rdData = {{TOP_W{1'b1}}, selReg, ~mergedPress};
  end
endmodule

// File: rtl/kpad_select_reg.sv
module kpad_select_reg
  import kpad_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] btnRaw,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData
);
  kpadStrobes_t strobes;

  kpad_ctrl u_ctrl (
    .wrEn    (wrEn),
    .wrData  (wrData),
    .strobes (strobes)
  );

  kpad_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .btnRaw  (btnRaw),
    .strobes (strobes),
    .rdData  (rdData)
  );
endmodule

// File: rtl/kpad_select_chk.sv
module kpad_select_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic [7:0] rdData
);
  assert_top_bits_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdData[7:6] == 2'b11);

  assert_sel_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> rdData[5:4] == $past(wrData[5:4]));

  assert_sel_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(rdData[5:4]));

  assert_none_sel_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdData[5:4] == 2'b11 |-> rdData[3:0] == 4'hF);
endmodule

bind kpad_select_reg kpad_select_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .wrData (wrData),
  .rdData (rdData)
);

// File: tb/test_kpad_select_reg.sv
module test_kpad_select_reg;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] btnRaw = 8'h00;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  int         nRun = 0;
  int         nFail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  kpad_select_reg i_kpad_select_reg (
    .clk(clk), .rstN(rstN), .btnRaw(btnRaw),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData)
  );

  function automatic logic [7:0] expRead(input logic [1:0] sel, input logic [7:0] btn);
    logic [3:0] nib;
    case (sel)
      2'b11: nib = 4'h0;
      2'b10: nib = btn[7:4];
      2'b01: nib = btn[3:0];
      default: nib = btn[7:4] | btn[3:0];
    endcase
    return {2'b11, sel, ~nib};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] v);
    @(negedge clk); wrEn = 1'b1; wrData = v;
    @(negedge clk); wrEn = 1'b0; wrData = 8'h00;
  endtask

  task automatic pressAndSettle(input logic [7:0] b);
    @(negedge clk); btnRaw = b;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    rstN = 1'b0;
    btnRaw = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset value", rdData, 8'hCF);
    @(negedge clk); rstN = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 after release", rdData, 8'hCF);
  endtask

  task automatic t_sel(input logic [1:0] sel, input string tag);
    writeReg({2'b00, sel, 4'h0});
    for (int i = 0; i < 4; i++) begin
      logic [7:0] b;
      b = (i == 0) ? 8'h00 : (i == 1) ? 8'h21 : (i == 2) ? 8'h90 : 8'hFF;
      pressAndSettle(b);
      check(tag, rdData, expRead(sel, b));
    end
  endtask

  task automatic t_ignored_bits;
    writeReg(8'hCF);
    pressAndSettle(8'h00);
    check("R3 ignored bits / R2 top bits", rdData, 8'hCF);
    writeReg(8'h3F);
    check("R3 select readback", rdData, 8'hFF);
  endtask

  task automatic t_write_gate;
    writeReg(8'h10);
    pressAndSettle(8'h05);
    @(negedge clk); wrData = 8'h20;
    @(negedge clk); wrData = 8'h30;
    @(negedge clk); wrData = 8'h00;
    #1;
    check("R9 no write without strobe", rdData, expRead(2'b01, 8'h05));
  endtask

  task automatic t_latency;
    writeReg(8'h10);
    pressAndSettle(8'h00);
    @(negedge clk); btnRaw = 8'h01;
    @(posedge clk); #1;
    check("R8 unchanged after one edge", rdData, 8'hDF);
    @(posedge clk); #1;
    check("R8 visible after two edges", rdData, 8'hDE);
  endtask

  initial begin
    t_reset();
    t_sel(2'b11, "R4 none selected");
    t_sel(2'b10, "R5 group 1 selected");
    t_sel(2'b01, "R6 group 0 selected");
    t_sel(2'b00, "R7 both merged");
    t_ignored_bits();
    t_write_gate();
    t_latency();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule